// File: doc/BRIEF.md
# Iterative AES Round Engine

This block runs the AES cipher or the AES inverse cipher on one 128-bit block. It completes one full round per clock. Expanding the key is left to the caller. On every cycle the engine puts out an index into the caller's expanded key table on `key_idx_o`, and the caller returns that 128-bit round key on `rkey_i` in the same cycle. The round count follows the key-length select: 10 rounds for 128-bit keys, 12 for 192-bit keys and 14 for 256-bit keys.

A start pulse captures the input block and applies the first key addition. The middle rounds and the final round follow, and the final round leaves out column mixing. A one-cycle done pulse then presents the result. Byte substitution is computed arithmetically rather than looked up. Each byte is inverted in GF(2^8) modulo x^8+x^4+x^3+x+1, as a power chain x^254, and then passes through the affine map. For decryption the same inverter sits between the inverse affine map and the output. A single inverter per byte therefore serves both directions.

Top module: `aes_round_engine`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `busy_o` and `done_o` are 0.
- R2: With `keylen_i`=0 and `decrypt_i`=0, the engine runs 10 rounds. The result is the standard AES-128 ciphertext of `state_i`. Byte 0 of the state is bits [127:120], and column c holds bytes 4c..4c+3, with row 0 in the top byte.
- R3: `keylen_i`=1 selects 12 rounds (192-bit key). `keylen_i`=2 selects 14 rounds (256-bit key), and `keylen_i`=3 behaves exactly like 2.
- R4: With `decrypt_i`=1, the engine applies the inverse cipher for the selected key length and returns the original plaintext from a ciphertext.
- R5: In the start cycle, `key_idx_o` is 0 for encryption and Nr for decryption. In each busy cycle it is the number of rounds done so far plus one when encrypting, and Nr minus that value when decrypting. The final round consumes index Nr when encrypting and index 0 when decrypting.
- R6: `done_o` rises exactly Nr+1 clock edges after the edge that samples `start_i`, counting that edge. It lasts one cycle, and `result_o` is valid during that cycle. `busy_o` is 1 from the edge after the start edge up to the done cycle.
- R7: While `busy_o` is 1, `start_i` and `state_i` are ignored, and the running block finishes with its correct result.
- R8: A start accepted in the cycle where `done_o` is 1 begins the next block with no idle cycle between the two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a block; sampled while not busy |
| decrypt_i | input | 1 | 0 = cipher, 1 = inverse cipher (sampled with start) |
| keylen_i | input | 2 | 0 = 128-bit, 1 = 192-bit, 2 or 3 = 256-bit key |
| state_i | input | 128 | Input block (sampled with start) |
| rkey_i | input | 128 | Round key for index `key_idx_o`, this cycle |
| key_idx_o | output | 4 | Index of the round key wanted this cycle |
| busy_o | output | 1 | Rounds in progress |
| done_o | output | 1 | One-cycle pulse, result valid |
| result_o | output | 128 | Output block |

## Verification
The bench builds the engine with its default parameters: 10, 12 and 14 rounds, and inverse column mixing factored onto the forward mixer. This puts the factored mixer and the shared inverter on the decrypt path under test. The reference vectors cover all three key lengths in both directions, plus select code 3, and the bench expands every key itself from its own S-box. While the rounds run it follows the requested key indices and counts the edges until done, so any misordered round key or off-by-one round count changes the output. Directed runs hold start high during a block and chain a second block into the done cycle.

// File: rtl/aes_rnd_pkg.sv
package aes_rnd_pkg;

   localparam logic [7:0] AFF_C     = 8'h63;
   localparam logic [7:0] AFF_INV_C = 8'h05;
   localparam logic [7:0] POLY_LOW  = 8'h1b;

   localparam logic [1:0] KL_128 = 2'd0;
   localparam logic [1:0] KL_192 = 2'd1;

   function automatic logic [7:0] gf_dbl(input logic [7:0] a);
      return {a[6:0], 1'b0} ^ (a[7] ? POLY_LOW : 8'h00);
   endfunction

   function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] acc;
      logic [7:0] p;
      acc = 8'h00;
      p   = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) acc = acc ^ p;
         p = gf_dbl(p);
      end
      return acc;
   endfunction

   // x^254 = product of x^(2^k) for k = 1..7; zero maps to zero
   function automatic logic [7:0] gf_inv(input logic [7:0] x);
      logic [7:0] acc;
      logic [7:0] p;
      acc = 8'h01;
      p   = x;
      for (int k = 1; k < 8; k++) begin
         p   = gf_mul(p, p);
         acc = gf_mul(acc, p);
      end
      return acc;
   endfunction

   function automatic logic [7:0] aff_fwd(input logic [7:0] x);
      logic [7:0] b;
      for (int i = 0; i < 8; i++)
         b[i] = x[i] ^ x[(i+4)%8] ^ x[(i+5)%8] ^ x[(i+6)%8] ^ x[(i+7)%8] ^ AFF_C[i];
      return b;
   endfunction

   function automatic logic [7:0] aff_inv(input logic [7:0] x);
      logic [7:0] b;
      for (int i = 0; i < 8; i++)
         b[i] = x[(i+2)%8] ^ x[(i+5)%8] ^ x[(i+7)%8] ^ AFF_INV_C[i];
      return b;
   endfunction

endpackage

// File: rtl/aes_byte_sub.sv
module aes_byte_sub
   import aes_rnd_pkg::*;
(
   input  logic       dec_i,
   input  logic [7:0] a_i,
   output logic [7:0] y_i
);

   logic [7:0] pre_w;
   logic [7:0] inv_w;

   always_comb begin
      pre_w = dec_i ? aff_inv(a_i) : a_i;
      inv_w = gf_inv(pre_w);
      y_i   = dec_i ? inv_w : aff_fwd(inv_w);
   end

endmodule

// File: rtl/aes_col_mix.sv
module aes_col_mix
   import aes_rnd_pkg::*;
#(
   parameter bit INV_MIX_FACTORED = 1'b1
)(
   input  logic        dec_i,
   input  logic [31:0] col_i,
   output logic [31:0] col_o
);

   logic [7:0] a [4];
   logic [7:0] b [4];

   always_comb begin
      for (int i = 0; i < 4; i++) a[i] = col_i[31-8*i -: 8];
   end

   generate
      if (INV_MIX_FACTORED) begin : g_factored
         logic [7:0] f [4];
         always_comb begin
            logic [7:0] u;
            logic [7:0] v;
            u = dec_i ? gf_dbl(gf_dbl(a[0] ^ a[2])) : 8'h00;
            v = dec_i ? gf_dbl(gf_dbl(a[1] ^ a[3])) : 8'h00;
            f[0] = a[0] ^ u;
            f[1] = a[1] ^ v;
            f[2] = a[2] ^ u;
            f[3] = a[3] ^ v;
            for (int i = 0; i < 4; i++)
               b[i] = gf_dbl(f[i]) ^ gf_dbl(f[(i+1)%4]) ^ f[(i+1)%4]
                    ^ f[(i+2)%4] ^ f[(i+3)%4];
         end
      end else begin : g_direct
         always_comb begin
            for (int i = 0; i < 4; i++) begin
               if (dec_i)
                  b[i] = gf_mul(a[i], 8'h0e) ^ gf_mul(a[(i+1)%4], 8'h0b)
                       ^ gf_mul(a[(i+2)%4], 8'h0d) ^ gf_mul(a[(i+3)%4], 8'h09);
               else
                  b[i] = gf_dbl(a[i]) ^ gf_dbl(a[(i+1)%4]) ^ a[(i+1)%4]
                       ^ a[(i+2)%4] ^ a[(i+3)%4];
            end
         end
      end
   endgenerate

   always_comb begin
      for (int i = 0; i < 4; i++) col_o[31-8*i -: 8] = b[i];
   end

endmodule

// File: rtl/aes_round_path.sv
module aes_round_path #(
   parameter int BLK_W            = 128,
   parameter bit INV_MIX_FACTORED = 1'b1
)(
   input  logic             dec_i,
   input  logic             last_i,
   input  logic [BLK_W-1:0] st_i,
   input  logic [BLK_W-1:0] rk_i,
   output logic [BLK_W-1:0] st_o
);

   localparam int NBYTES = BLK_W / 8;
   localparam int NCOLS  = NBYTES / 4;

   logic [BLK_W-1:0] sub_w;
   logic [BLK_W-1:0] shf_w;
   logic [BLK_W-1:0] mix_in_w;
   logic [BLK_W-1:0] mix_w;

   generate
      for (genvar n = 0; n < NBYTES; n++) begin : g_sub
         aes_byte_sub u_sub (
            .dec_i (dec_i),
            .a_i   (st_i[BLK_W-1-8*n -: 8]),
            .y_i   (sub_w[BLK_W-1-8*n -: 8])
         );
      end
   endgenerate

   // row r of column c takes byte from column (c+r) going forward, (c-r) going back
   always_comb begin
      for (int c = 0; c < NCOLS; c++) begin
         for (int r = 0; r < 4; r++) begin
            int src;
            src = dec_i ? (c - r + NCOLS) % NCOLS : (c + r) % NCOLS;
            shf_w[BLK_W-1-8*(4*c+r) -: 8] = sub_w[BLK_W-1-8*(4*src+r) -: 8];
         end
      end
   end

   assign mix_in_w = dec_i ? (shf_w ^ rk_i) : shf_w;

   generate
      for (genvar c = 0; c < NCOLS; c++) begin : g_mix
         aes_col_mix #(.INV_MIX_FACTORED(INV_MIX_FACTORED)) u_mix (
            .dec_i (dec_i),
            .col_i (mix_in_w[BLK_W-1-32*c -: 32]),
            .col_o (mix_w[BLK_W-1-32*c -: 32])
         );
      end
   endgenerate

   always_comb begin
      logic [BLK_W-1:0] sel;
      sel  = last_i ? mix_in_w : mix_w;
      st_o = dec_i ? sel : (sel ^ rk_i);
   end

endmodule

// File: rtl/aes_round_engine.sv
module aes_round_engine
   import aes_rnd_pkg::*;
#(
   parameter int BLK_W            = 128,
   parameter int NR_K128          = 10,
   parameter int NR_K192          = 12,
   parameter int NR_K256          = 14,
   parameter bit INV_MIX_FACTORED = 1'b1,
   localparam int IDX_W           = $clog2(NR_K256 + 1)
)(
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic             decrypt_i,
   input  logic [1:0]       keylen_i,
   input  logic [BLK_W-1:0] state_i,
   input  logic [BLK_W-1:0] rkey_i,
   output logic [IDX_W-1:0] key_idx_o,
   output logic             busy_o,
   output logic             done_o,
   output logic [BLK_W-1:0] result_o
);

   generate
      if (BLK_W != 128) begin : g_chk_w
         $error("aes_round_engine: BLK_W must be 128");
      end
      if (!(NR_K128 > 0 && NR_K128 < NR_K192 && NR_K192 < NR_K256)) begin : g_chk_nr
         $error("aes_round_engine: round counts must be positive and increasing");
      end
   endgenerate

   function automatic logic [IDX_W-1:0] rounds_for(input logic [1:0] kl);
      case (kl)
         KL_128:  return IDX_W'(NR_K128);
         KL_192:  return IDX_W'(NR_K192);
         default: return IDX_W'(NR_K256);
      endcase
   endfunction

   logic [BLK_W-1:0] st_q;
   logic [IDX_W-1:0] cnt_q;
   logic [IDX_W-1:0] nr_q;
   logic             dec_q;
   logic             busy_q;
   logic             done_q;
   logic             last_w;
   logic [BLK_W-1:0] nxt_w;

   assign last_w = (cnt_q == nr_q);

   aes_round_path #(.BLK_W(BLK_W), .INV_MIX_FACTORED(INV_MIX_FACTORED)) u_path (
      .dec_i  (dec_q),
      .last_i (last_w),
      .st_i   (st_q),
      .rk_i   (rkey_i),
      .st_o   (nxt_w)
   );

   always_comb begin
      if (busy_q)
         key_idx_o = dec_q ? (nr_q - cnt_q) : cnt_q;
      else
         key_idx_o = decrypt_i ? rounds_for(keylen_i) : '0;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         st_q   <= '0;
         cnt_q  <= '0;
         nr_q   <= '0;
         dec_q  <= 1'b0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (start_i) begin
               st_q   <= state_i ^ rkey_i;
               cnt_q  <= IDX_W'(1);
               nr_q   <= rounds_for(keylen_i);
               dec_q  <= decrypt_i;
               busy_q <= 1'b1;
            end
         end else begin
            st_q <= nxt_w;
            if (last_w) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q + IDX_W'(1);
            end
         end
      end
   end

   assign busy_o   = busy_q;
   assign done_o   = done_q;
   assign result_o = st_q;

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o); // R6
   AST_DONE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> $past(busy_o)); // R6
   AST_BUSY_UNTIL_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && !last_w) |=> (busy_o && $stable(nr_q) && $stable(dec_q))); // R7
   AST_IDX_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o |-> (key_idx_o <= nr_q)); // R5
   AST_ENC_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && $past(busy_o) && !dec_q) |-> (key_idx_o == $past(key_idx_o) + IDX_W'(1))); // R5
   AST_DEC_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && $past(busy_o) && dec_q) |-> (key_idx_o == $past(key_idx_o) - IDX_W'(1))); // R5

endmodule

// File: tb/aes_round_engine_tb.sv
module aes_round_engine_tb;

   localparam int VW = 515;
   localparam int NV = 8;
   // {keylen[2], decrypt[1], key[256], input[128], expected[128]}
   localparam logic [VW-1:0] VEC [NV] = '{
      {2'd0, 1'b0, 256'h000102030405060708090a0b0c0d0e0f_00000000000000000000000000000000,
       128'h00112233445566778899aabbccddeeff, 128'h69c4e0d86a7b0430d8cdb78070b4c55a},
      {2'd0, 1'b1, 256'h000102030405060708090a0b0c0d0e0f_00000000000000000000000000000000,
       128'h69c4e0d86a7b0430d8cdb78070b4c55a, 128'h00112233445566778899aabbccddeeff},
      {2'd1, 1'b0, 256'h000102030405060708090a0b0c0d0e0f1011121314151617_0000000000000000,
       128'h00112233445566778899aabbccddeeff, 128'hdda97ca4864cdfe06eaf70a0ec0d7191},
      {2'd1, 1'b1, 256'h000102030405060708090a0b0c0d0e0f1011121314151617_0000000000000000,
       128'hdda97ca4864cdfe06eaf70a0ec0d7191, 128'h00112233445566778899aabbccddeeff},
      {2'd2, 1'b0, 256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f,
       128'h00112233445566778899aabbccddeeff, 128'h8ea2b7ca516745bfeafc49904b496089},
      {2'd3, 1'b1, 256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f,
       128'h8ea2b7ca516745bfeafc49904b496089, 128'h00112233445566778899aabbccddeeff},
      {2'd0, 1'b0, 256'h2b7e151628aed2a6abf7158809cf4f3c_00000000000000000000000000000000,
       128'h3243f6a8885a308d313198a2e0370734, 128'h3925841d02dc09fbdc118597196a0b32},
      {2'd0, 1'b1, 256'h2b7e151628aed2a6abf7158809cf4f3c_00000000000000000000000000000000,
       128'h3925841d02dc09fbdc118597196a0b32, 128'h3243f6a8885a308d313198a2e0370734}
   };

   logic         clk_i = 1'b0;
   logic         rst_ni = 1'b0;
   logic         start_i = 1'b0;
   logic         decrypt_i = 1'b0;
   logic [1:0]   keylen_i = 2'd0;
   logic [127:0] state_i = '0;
   logic [127:0] rkey_i = '0;
   logic [3:0]   key_idx_o;
   logic         busy_o;
   logic         done_o;
   logic [127:0] result_o;

   int n_cmp = 0;
   int n_bad = 0;

   logic [7:0]   sb [256];
   logic [127:0] rks [NV][15];

   always #2 clk_i = ~clk_i;

   aes_round_engine u_dut (
      .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .decrypt_i(decrypt_i),
      .keylen_i(keylen_i), .state_i(state_i), .rkey_i(rkey_i),
      .key_idx_o(key_idx_o), .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
   );

   function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
      logic [15:0] prod;
      prod = '0;
      for (int i = 0; i < 8; i++) if (b[i]) prod = prod ^ (16'(a) << i);
      for (int i = 15; i >= 8; i--) if (prod[i]) prod = prod ^ (16'h011b << (i - 8));
      return prod[7:0];
   endfunction

   function automatic logic [7:0] rotl8(input logic [7:0] x, input int k);
      return (x << k) | (x >> (8 - k));
   endfunction

   function automatic int nr_of(input logic [1:0] kl);
      return (kl == 2'd0) ? 10 : (kl == 2'd1) ? 12 : 14;
   endfunction

   function automatic logic [31:0] subw(input logic [31:0] w);
      return {sb[w[31:24]], sb[w[23:16]], sb[w[15:8]], sb[w[7:0]]};
   endfunction

   task automatic build_tables();
      for (int x = 0; x < 256; x++) begin
         logic [7:0] inv;
         inv = 8'h00;
         for (int j = 1; j < 256; j++) if (bmul(8'(x), 8'(j)) == 8'h01) inv = 8'(j);
         sb[x] = inv ^ rotl8(inv, 1) ^ rotl8(inv, 2) ^ rotl8(inv, 3) ^ rotl8(inv, 4) ^ 8'h63;
      end
      for (int v = 0; v < NV; v++) begin
         logic [31:0] w [60];
         logic [7:0]  rc;
         int nk, nr;
         nr = nr_of(VEC[v][514:513]);
         nk = nr - 6;
         rc = 8'h01;
         for (int i = 0; i < nk; i++) w[i] = VEC[v][511-32*i -: 32];
         for (int i = nk; i < 4*(nr+1); i++) begin
            logic [31:0] t;
            t = w[i-1];
            if (i % nk == 0) begin
               t = subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
               rc = bmul(rc, 8'h02);
            end else if (nk > 6 && i % nk == 4) begin
               t = subw(t);
            end
            w[i] = w[i-nk] ^ t;
         end
         for (int r = 0; r <= nr; r++) rks[v][r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
      end
   endtask

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic report();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   logic idx_bad;

   task automatic drive_start(input int v);
      keylen_i  = VEC[v][514:513];
      decrypt_i = VEC[v][512];
      state_i   = VEC[v][255:128];
      start_i   = 1'b1;
      #1;
      // R5: start-cycle index is 0 (encrypt) or Nr (decrypt)
      if (key_idx_o != (VEC[v][512] ? 4'(nr_of(VEC[v][514:513])) : 4'd0)) idx_bad = 1'b1;
      rkey_i = rks[v][key_idx_o];
   endtask

   task automatic run_tail(input int v, input int next_v, input bit hold,
                           output logic [127:0] res, output int edges, output bit busy_bad);
      int nr;
      nr = nr_of(VEC[v][514:513]);
      edges = 0;
      busy_bad = 1'b0;
      res = '0;
      forever begin
         @(posedge clk_i);
         edges++;
         @(negedge clk_i);
         if (hold) state_i = ~state_i;
         else      start_i = 1'b0;
         if (done_o) begin
            res = result_o;
            if (next_v >= 0) drive_start(next_v);
            else start_i = 1'b0;
            break;
         end
         if (!busy_o) busy_bad = 1'b1;
         if (key_idx_o != (VEC[v][512] ? 4'(nr - edges) : 4'(edges))) idx_bad = 1'b1;
         #1 rkey_i = rks[v][key_idx_o];
         if (edges > 40) break;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk_i);
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      report();
      $finish;
   end

   initial begin
      logic [127:0] res;
      logic [127:0] res2;
      int  edges;
      int  edges2;
      bit  bb;
      build_tables();
      repeat (3) @(posedge clk_i);
      @(negedge clk_i);
      chk("R1 busy in reset", {127'b0, busy_o}, '0);
      chk("R1 done in reset", {127'b0, done_o}, '0);
      rst_ni = 1'b1;
      @(negedge clk_i);
      chk("R1 busy after reset", {127'b0, busy_o}, '0);
      chk("R1 done after reset", {127'b0, done_o}, '0);

      // vector table: R2 (128 enc), R3 (192/256 incl. code 3), R4 (decrypt)
      for (int v = 0; v < NV; v++) begin
         string tag;
         int nr;
         nr = nr_of(VEC[v][514:513]);
         tag = VEC[v][512] ? "R4 decrypt" : (nr == 10 ? "R2 encrypt" : "R3 encrypt");
         idx_bad = 1'b0;
         @(negedge clk_i);
         drive_start(v);
         run_tail(v, -1, 1'b0, res, edges, bb);
         chk(tag, res, VEC[v][127:0]);
         chk("R3/R6 latency in edges", 128'(edges), 128'(nr + 1));
         chk("R5 key index sequence", {127'b0, idx_bad}, '0);
         chk("R6 busy through rounds", {127'b0, bb}, '0);
         @(negedge clk_i);
         chk("R6 done is a single pulse", {127'b0, done_o}, '0);
      end

      // R7: start held high and state toggled during the run
      idx_bad = 1'b0;
      @(negedge clk_i);
      drive_start(6);
      run_tail(6, -1, 1'b1, res, edges, bb);
      chk("R7 start ignored while busy", res, VEC[6][127:0]);
      chk("R7 latency unchanged", 128'(edges), 128'(11));

      // R8: second block started in the done cycle of the first
      idx_bad = 1'b0;
      @(negedge clk_i);
      drive_start(4);
      run_tail(4, 1, 1'b0, res, edges, bb);
      run_tail(1, -1, 1'b0, res2, edges2, bb);
      chk("R8 first block", res, VEC[4][127:0]);
      chk("R8 chained block result", res2, VEC[1][127:0]);
      chk("R8 chained block latency", 128'(edges2), 128'(11));
      chk("R8 chained key indices", {127'b0, idx_bad}, '0);

      report();
      $finish;
   end

endmodule